// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read serial NOR flash as if it were plain memory. A bus read whose address falls in the window of one chip select turns into one full serial flash read: an 8-bit read opcode, a 3- or 4-byte address, a programmable run of dummy byte slots, and then 32 data bits taken in on one, two or four data lines. The 32 bits are packed into a bus word and handed back over a simple request/ready handshake.

The upper bits of the bus address pick the chip select and the lower `WIN_AW` bits are the byte offset inside that flash. Each chip select has its own 32-bit control word. The control word packs the opcode, the dummy count, the data width and the operating mode. A shared address-mode word holds, for each chip select, a bit pair that selects 4-byte addressing. The serial clock runs at half the system clock in SPI mode 0.

Top module: `xip_read_engine`

## Requirements
- R1: The chip select is taken from bus address bits `[BUS_AW-1:WIN_AW]`. Only that chip select's `spi_cs_n` bit goes low. The flash address sent is the offset in bits `[WIN_AW-1:0]`.
- R2: The opcode in control bits 23:16 of the selected chip select goes out first. It is sent MSB first on io0 only (`spi_io_oe` = 0001), over 8 serial clocks.
- R3: The address is 4 bytes when both `addr_mode` bits `cs` and `cs+4` are set. Otherwise it is 3 bytes. It is sent MSB first on io0 only, and io1 to io3 are never driven.
- R4: The dummy count N is {control bit 14, control bits 7:6}. The dummy phase lasts exactly 8*N serial clocks with every data line released (`spi_io_oe` = 0).
- R5: Control bit 30 selects quad data on io3..io0. Otherwise, bit 29 selects dual data on io1..io0. Otherwise the data is single on io1. The first bit of each group is on the highest line. Lines the selected width does not use are ignored.
- R6: The response word carries the first received byte in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R7: A fetch is performed only when control bits 1:0 equal 1 (read). For any other value, the request completes with `rsp_data` = 0 and no chip select is asserted.
- R8: Chip select is low from before the first opcode rising edge until after the last data rising edge. At most one chip select is low at a time. `spi_sclk` is low whenever every chip select is high.
- R9: `req_ready` pulses only while every chip select is high. Between two transactions every chip select stays high for at least 2 clock cycles, which is one serial clock.
- R10: A read transaction has exactly 8 + A + 8*N + 32/W rising serial clock edges, where A is 24 or 32 and W is 1, 2 or 4.
- R11: In reset, every chip select is high, `spi_sclk` is low, no data line is driven and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus read request, held until `req_ready` |
| req_addr | input | BUS_AW | Bus byte address (chip select and offset) |
| req_ready | output | 1 | One-cycle completion pulse; `rsp_data` is valid with it |
| rsp_data | output | 32 | Read data word |
| ctrl_regs | input | 32*NUM_CS | Per-chip-select control words, chip select 0 in the low word |
| addr_mode | input | 32 | Shared address-mode word |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_o | output | 4 | Serial data out |
| spi_io_oe | output | 4 | Output enables for the data lines |
| spi_io_i | input | 4 | Serial data in |

## Verification
The bound checker checks the framing rules on every cycle. It confirms that at most one chip select is low, that the serial clock is parked low while the flash is deselected, that io1 to io3 are never driven, and that completion is signalled only after chip select is released and the deselect period lasts more than a single cycle. The bench's flash model is needed to show everything that depends on content and count. It checks the captured opcode and address, the exact number of clock edges for each address width, dummy count and data width, that the data lines are released through the dummy and data phases, the byte order of the returned word, and that non-read modes never touch the bus. The sweep covers every combination of chip select, data width, address width and dummy count.

// File: rtl/xip_pkg.sv
package xip_pkg;

    localparam int unsigned CTRL_W    = 32;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned SEQ_CNT_W = 6;

    typedef enum logic [1:0] {
        LINES_1 = 2'd0,
        LINES_2 = 2'd1,
        LINES_4 = 2'd2
    } lanes_e;

    typedef enum logic [1:0] {
        OPM_NORMAL = 2'd0,
        OPM_READ   = 2'd1,
        OPM_WRITE  = 2'd2,
        OPM_USER   = 2'd3
    } opmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPC,
        SQ_ADR,
        SQ_DUM,
        SQ_DAT,
        SQ_TAIL,
        SQ_RESP,
        SQ_GAP
    } seq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] dummy;
        lanes_e     lanes;
        opmode_e    mode;
        logic       wide_addr;
    } rd_cfg_t;

    // Data phase width: quad has priority over dual.
    function automatic lanes_e lanes_from_ctrl(input logic [CTRL_W-1:0] c);
        if (c[30])      return LINES_4;
        else if (c[29]) return LINES_2;
        else            return LINES_1;
    endfunction

    // The dummy count is split: high bit at 14, low pair at 7:6.
    function automatic logic [2:0] dummy_from_ctrl(input logic [CTRL_W-1:0] c);
        return {c[14], c[7:6]};
    endfunction

    function automatic rd_cfg_t make_cfg(input logic [CTRL_W-1:0] c, input logic wide);
        rd_cfg_t r;
        r.opcode    = c[23:16];
        r.dummy     = dummy_from_ctrl(c);
        r.lanes     = lanes_from_ctrl(c);
        r.mode      = opmode_e'(c[1:0]);
        r.wide_addr = wide;
        return r;
    endfunction

    // Serial clocks needed for one 32-bit data word.
    function automatic logic [SEQ_CNT_W-1:0] data_cycles(input lanes_e l);
        case (l)
            LINES_4: return SEQ_CNT_W'(WORD_W / 4);
            LINES_2: return SEQ_CNT_W'(WORD_W / 2);
            default: return SEQ_CNT_W'(WORD_W);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] rx_merge(input logic [WORD_W-1:0] acc,
                                                   input logic [3:0] io,
                                                   input lanes_e l);
        case (l)
            LINES_4: return {acc[WORD_W-5:0], io[3:0]};
            LINES_2: return {acc[WORD_W-3:0], io[1:0]};
            default: return {acc[WORD_W-2:0], io[1]};
        endcase
    endfunction

    // First received byte ends up in the lowest lane.
    function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[b*8 +: 8] = w[WORD_W-8-b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] addr_align(input logic [31:0] off, input logic wide);
        return wide ? off : {off[23:0], 8'h00};
    endfunction

endpackage

// File: rtl/xip_cfg_decode.sv
module xip_cfg_decode
    import xip_pkg::*;
#(
    parameter int NUM_CS = 2,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic [NUM_CS*CTRL_W-1:0] ctrl_regs,
    input  logic [31:0]              addr_mode,
    input  logic [CS_W-1:0]          cs_sel,
    output rd_cfg_t                  cfg
);

    rd_cfg_t per_cs [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        // 4-byte addressing needs both bits of the pair for this select.
        assign per_cs[g] = make_cfg(ctrl_regs[g*CTRL_W +: CTRL_W],
                                    addr_mode[g] & addr_mode[g+4]);
    end

    assign cfg = per_cs[cs_sel];

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{ctrl_regs, addr_mode};

endmodule

// File: rtl/xip_shift.sv
module xip_shift
    import xip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_load_val,
    input  logic              tx_shift,
    input  logic              rx_clear,
    input  logic              rx_capture,
    input  lanes_e            lanes,
    input  logic [3:0]        io_i,
    output logic              tx_bit,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
        end else if (tx_load) begin
            tx_sh <= tx_load_val;
        end else if (tx_shift) begin
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rx_clear) begin
            rx_sh <= '0;
        end else if (rx_capture) begin
            rx_sh <= rx_merge(rx_sh, io_i, lanes);
        end
    end

    assign tx_bit  = tx_sh[WORD_W-1];
    assign rx_word = lane_swap(rx_sh);

endmodule

// File: rtl/xip_seq.sv
module xip_seq
    import xip_pkg::*;
#(
    parameter int NUM_CS = 2,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [31:0]       req_off,
    input  rd_cfg_t           cfg,
    output logic              req_ready,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic              oe0,
    output logic              tx_load,
    output logic [WORD_W-1:0] tx_load_val,
    output logic              tx_shift,
    output logic              rx_clear,
    output logic              rx_capture,
    output lanes_e            lanes
);

    seq_state_e           st;
    logic [SEQ_CNT_W-1:0] cnt;
    logic [2:0]           dummy_q;
    lanes_e               lanes_q;
    logic                 wide_q;
    logic [31:0]          off_q;

    logic accept;
    logic fetch;
    logic serial;
    logic last_fall;

    assign accept    = (st == SQ_IDLE) && req_valid;
    assign fetch     = accept && (cfg.mode == OPM_READ);
    assign serial    = (st == SQ_OPC) || (st == SQ_ADR) || (st == SQ_DUM) || (st == SQ_DAT);
    assign last_fall = serial && sclk && (cnt == SEQ_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            sclk    <= 1'b0;
            cs_n    <= '1;
            oe0     <= 1'b0;
            cnt     <= '0;
            dummy_q <= '0;
            lanes_q <= LINES_1;
            wide_q  <= 1'b0;
            off_q   <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (accept) begin
                        dummy_q <= cfg.dummy;
                        lanes_q <= cfg.lanes;
                        wide_q  <= cfg.wide_addr;
                        off_q   <= req_off;
                        if (fetch) begin
                            cs_n <= ~(NUM_CS'(1) << req_cs);
                            oe0  <= 1'b1;
                            cnt  <= SEQ_CNT_W'(8);
                            st   <= SQ_OPC;
                        end else begin
                            st <= SQ_RESP;
                        end
                    end
                end
                SQ_OPC, SQ_ADR, SQ_DUM, SQ_DAT: begin
                    if (!sclk) begin
                        sclk <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        if (cnt != SEQ_CNT_W'(1)) begin
                            cnt <= cnt - SEQ_CNT_W'(1);
                        end else begin
                            case (st)
                                SQ_OPC: begin
                                    cnt <= wide_q ? SEQ_CNT_W'(32) : SEQ_CNT_W'(24);
                                    st  <= SQ_ADR;
                                end
                                SQ_ADR: begin
                                    oe0 <= 1'b0;
                                    if (dummy_q != 3'd0) begin
                                        cnt <= SEQ_CNT_W'({dummy_q, 3'b000});
                                        st  <= SQ_DUM;
                                    end else begin
                                        cnt <= data_cycles(lanes_q);
                                        st  <= SQ_DAT;
                                    end
                                end
                                SQ_DUM: begin
                                    cnt <= data_cycles(lanes_q);
                                    st  <= SQ_DAT;
                                end
                                default: st <= SQ_TAIL;
                            endcase
                        end
                    end
                end
                SQ_TAIL: begin
                    cs_n <= '1;
                    st   <= SQ_RESP;
                end
                SQ_RESP: st <= SQ_GAP;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_load     = 1'b0;
        tx_load_val = '0;
        if (fetch) begin
            tx_load     = 1'b1;
            tx_load_val = {cfg.opcode, {(WORD_W-8){1'b0}}};
        end else if (last_fall && (st == SQ_OPC)) begin
            tx_load     = 1'b1;
            tx_load_val = addr_align(off_q, wide_q);
        end
    end

    assign tx_shift   = ((st == SQ_OPC) || (st == SQ_ADR)) && sclk && !last_fall;
    assign rx_clear   = accept;
    assign rx_capture = (st == SQ_DAT) && !sclk;
    assign req_ready  = (st == SQ_RESP);
    assign lanes      = lanes_q;

endmodule

// File: rtl/xip_read_engine.sv
module xip_read_engine
    import xip_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int WIN_AW = 24,
    localparam int CS_W = $clog2(NUM_CS),
    localparam int BUS_AW = WIN_AW + CS_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [BUS_AW-1:0]        req_addr,
    output logic                     req_ready,
    output logic [WORD_W-1:0]        rsp_data,
    input  logic [NUM_CS*CTRL_W-1:0] ctrl_regs,
    input  logic [31:0]              addr_mode,
    output logic                     spi_sclk,
    output logic [NUM_CS-1:0]        spi_cs_n,
    output logic [3:0]               spi_io_o,
    output logic [3:0]               spi_io_oe,
    input  logic [3:0]               spi_io_i
);

    logic [CS_W-1:0]   cs_sel;
    logic [31:0]       off;
    rd_cfg_t           cfg;
    logic              oe0;
    logic              tx_load;
    logic [WORD_W-1:0] tx_load_val;
    logic              tx_shift;
    logic              rx_clear;
    logic              rx_capture;
    lanes_e            lanes;
    logic              tx_bit;

    assign cs_sel = req_addr[BUS_AW-1 -: CS_W];
    assign off    = 32'(req_addr[WIN_AW-1:0]);

    xip_cfg_decode #(.NUM_CS(NUM_CS)) u_cfg (
        .ctrl_regs (ctrl_regs),
        .addr_mode (addr_mode),
        .cs_sel    (cs_sel),
        .cfg       (cfg)
    );

    xip_seq #(.NUM_CS(NUM_CS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_cs      (cs_sel),
        .req_off     (off),
        .cfg         (cfg),
        .req_ready   (req_ready),
        .sclk        (spi_sclk),
        .cs_n        (spi_cs_n),
        .oe0         (oe0),
        .tx_load     (tx_load),
        .tx_load_val (tx_load_val),
        .tx_shift    (tx_shift),
        .rx_clear    (rx_clear),
        .rx_capture  (rx_capture),
        .lanes       (lanes)
    );

    xip_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .tx_load     (tx_load),
        .tx_load_val (tx_load_val),
        .tx_shift    (tx_shift),
        .rx_clear    (rx_clear),
        .rx_capture  (rx_capture),
        .lanes       (lanes),
        .io_i        (spi_io_i),
        .tx_bit      (tx_bit),
        .rx_word     (rsp_data)
    );

    // Command and address use io0 only.
    assign spi_io_o  = {3'b000, tx_bit};
    assign spi_io_oe = {3'b000, oe0};

endmodule

// File: rtl/xip_read_engine_chk.sv
module xip_read_engine_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic              spi_sclk,
    input logic [3:0]        spi_io_oe,
    input logic              req_ready
);

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    // R8
    sclk_park_chk: assert property (@(posedge clk) disable iff (rst)
        (&spi_cs_n) |-> !spi_sclk);

    // R3
    single_line_out_chk: assert property (@(posedge clk) disable iff (rst)
        spi_io_oe[3:1] == 3'b000);

    // R9
    ready_released_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&spi_cs_n));

    // R9
    deselect_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(&spi_cs_n) |=> (&spi_cs_n));

    // R8
    oe_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (&spi_cs_n) |-> (spi_io_oe == 4'b0000));

endmodule

bind xip_read_engine xip_read_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_io_oe (spi_io_oe),
    .req_ready (req_ready)
);

// File: tb/tb_xip_read_engine.sv
module tb_xip_read_engine;

    localparam int NUM_CS = 2;
    localparam int WIN_AW = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_ready;
    logic [31:0] rsp_data;
    logic [63:0] ctrl_regs = '0;
    logic [31:0] addr_mode = '0;
    logic        spi_sclk;
    logic [1:0]  spi_cs_n;
    logic [3:0]  spi_io_o;
    logic [3:0]  spi_io_oe;
    logic [3:0]  io_in = 4'h0;

    always #10 clk = ~clk;

    xip_read_engine #(.NUM_CS(NUM_CS), .WIN_AW(WIN_AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_data(rsp_data), .ctrl_regs(ctrl_regs),
        .addr_mode(addr_mode), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(io_in)
    );

    int checks = 0;
    int errors = 0;

    // Current transaction settings known to the flash model.
    int          m_cs = 0;
    int          m_w = 1;
    int          m_dummy = 0;
    int          m_abits = 24;
    logic [31:0] m_addr = '0;

    function automatic logic [7:0] flash_byte(input int cs, input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ (cs != 0 ? 8'hC3 : 8'h3C);
    endfunction

    function automatic logic [31:0] flash_stream(input int cs, input logic [31:0] a);
        return {flash_byte(cs, a), flash_byte(cs, a + 1), flash_byte(cs, a + 2), flash_byte(cs, a + 3)};
    endfunction

    // Flash model: counts rising edges, captures opcode and address, checks enables.
    wire        all_high = &spi_cs_n;
    int         pcnt = 0;
    int         last_pcnt = 0;
    logic [7:0] cap_op = '0, last_op = '0;
    logic [31:0] cap_addr = '0, last_addr = '0;
    logic       oe_bad = 1'b0, last_bad = 1'b0;
    logic [1:0] hit_cs = 2'b11, last_cs = 2'b11;

    always @(posedge spi_sclk or posedge all_high) begin
        if (all_high) begin
            last_pcnt <= pcnt;
            last_op   <= cap_op;
            last_addr <= cap_addr;
            last_bad  <= oe_bad;
            last_cs   <= hit_cs;
            pcnt      <= 0;
            cap_op    <= '0;
            cap_addr  <= '0;
            oe_bad    <= 1'b0;
        end else begin
            pcnt   <= pcnt + 1;
            hit_cs <= spi_cs_n;
            if (pcnt < 8) begin
                cap_op <= {cap_op[6:0], spi_io_o[0]};
                if (spi_io_oe != 4'b0001) oe_bad <= 1'b1;
            end else if (pcnt < 8 + m_abits) begin
                cap_addr <= {cap_addr[30:0], spi_io_o[0]};
                if (spi_io_oe != 4'b0001) oe_bad <= 1'b1;
            end else if (spi_io_oe != 4'b0000) begin
                oe_bad <= 1'b1;
            end
        end
    end

    always @(negedge spi_sclk) begin
        int hdr;
        int j;
        logic [31:0] s;
        logic [3:0]  bits;
        hdr = 8 + m_abits + 8 * m_dummy;
        if (!all_high && pcnt >= hdr) begin
            j = pcnt - hdr;
            s = flash_stream(m_cs, m_addr);
            bits = 4'((s >> (32 - (j + 1) * m_w)) & ((1 << m_w) - 1));
            if (m_w == 1)      io_in <= {2'b11, bits[0], ~bits[0]};
            else if (m_w == 2) io_in <= {~bits[1:0], bits[1:0]};
            else               io_in <= bits;
        end
    end

    // Deselect length monitor and chip-select fall counter.
    int high_run = 0;
    int min_gap = 1000;
    int cs_falls = 0;
    logic prev_high = 1'b1;
    always @(posedge clk) begin
        if (!rst) begin
            if (all_high) high_run <= high_run + 1;
            else high_run <= 0;
            if (prev_high && !all_high) begin
                cs_falls <= cs_falls + 1;
                if (high_run < min_gap) min_gap <= high_run;
            end
            prev_high <= all_high;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one request and return the response word; timeout counts as failure.
    task automatic bus_read(input int cs, input logic [23:0] off, output logic [31:0] got);
        int n;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {1'(cs), off};
        n = 0;
        @(negedge clk);
        while (!req_ready && n < 3000) begin
            @(negedge clk);
            n++;
        end
        got = rsp_data;
        req_valid = 1'b0;
        if (n >= 3000) chk(1'b0, "R9", "request timeout", 32'(n), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input int cs, input logic [23:0] off, input logic [31:0] ctrl,
                        input bit four, input bit half_pair);
        logic [31:0] got, exp_word, s;
        int exp_cnt;
        ctrl_regs[cs*32 +: 32] = ctrl;
        addr_mode = 32'h0;
        if (four)      addr_mode = (32'h11 << cs);
        if (half_pair) addr_mode = (32'h10 << cs);
        m_cs    = cs;
        m_w     = ctrl[30] ? 4 : (ctrl[29] ? 2 : 1);
        m_dummy = int'({ctrl[14], ctrl[7:6]});
        m_abits = four ? 32 : 24;
        m_addr  = {8'h00, off};
        bus_read(cs, off, got);
        s = flash_stream(cs, m_addr);
        exp_word = {s[7:0], s[15:8], s[23:16], s[31:24]};
        exp_cnt  = 8 + m_abits + 8 * m_dummy + 32 / m_w;
        // R5 R6: data word assembled from the selected lines, first byte low
        chk(got == exp_word, "R6", "data word", got, exp_word);
        // R2: opcode
        chk(last_op == ctrl[23:16], "R2", "opcode", 32'(last_op), 32'(ctrl[23:16]));
        // R3 R1: address bytes equal the window offset
        chk(last_addr == m_addr, "R3", "address", last_addr, m_addr);
        // R10 R4: serial clock count
        chk(last_pcnt == exp_cnt, "R10", "rising edges", 32'(last_pcnt), 32'(exp_cnt));
        // R4: enables during each phase
        chk(!last_bad, "R4", "line enables", 32'(last_bad), 32'd0);
        // R1: only the addressed select went low
        chk(last_cs == ~(2'(1) << cs), "R1", "chip select", 32'(last_cs), 32'(~(2'(1) << cs)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int falls0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(spi_cs_n == 2'b11, "R11", "cs_n in reset", 32'(spi_cs_n), 32'h3);
        chk(spi_sclk == 1'b0 && spi_io_oe == 4'h0 && req_ready == 1'b0, "R11",
            "sclk/oe/ready in reset", {spi_sclk, spi_io_oe, req_ready}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 R5 R6 R10: full sweep
        for (int cs = 0; cs < 2; cs++)
            for (int ln = 0; ln < 3; ln++)
                for (int fb = 0; fb < 2; fb++)
                    for (int d = 0; d < 8; d++) begin
                        logic [31:0] c;
                        logic [23:0] off;
                        logic [7:0]  op;
                        op  = 8'h0B ^ 8'(d * 17 + ln * 5 + cs * 64 + fb * 2);
                        off = 24'hA5F00D ^ 24'(d * 24'h0F1E2D) ^ 24'(ln * 24'h333001) ^ 24'(fb * 24'h5A0000);
                        c   = 32'h0000_2A04 | 32'h1 | (32'(op) << 16) |
                              (32'(d >> 2) << 14) | (32'(d & 3) << 6) |
                              (ln == 1 ? 32'h2000_0000 : 32'h0) | (ln == 2 ? 32'h4000_0000 : 32'h0);
                        xfer(cs, off, c, fb != 0, 1'b0);
                    end

        // R3: only one bit of the pair set keeps 3-byte addressing
        xfer(1, 24'hFFFFFF, 32'h0003_0041, 1'b0, 1'b1);
        // R5: both width bits set selects quad
        xfer(0, 24'h000000, 32'h7013_4001, 1'b1, 1'b0);

        // R7: non-read modes finish with zero and no select activity
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            falls0 = cs_falls;
            ctrl_regs[31:0] = 32'h4003_0000 | 32'(m);
            bus_read(0, 24'h123456, got);
            chk(got == 32'h0, "R7", "non-read data", got, 32'h0);
            chk(cs_falls == falls0, "R7", "non-read select", 32'(cs_falls), 32'(falls0));
        end

        // R9: deselect lasted at least one serial clock
        chk(min_gap >= 2, "R9", "deselect gap", 32'(min_gap), 32'd2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule